// File: doc/BRIEF.md
# Ramp and Ripple Test Pattern Generator

This block paints a synthetic RGB test image for a display pipeline. For each incoming pixel it receives the column and line position, a pixel-valid qualifier and two timing strobes. One strobe marks the first pixel of every line and the other marks the first pixel of a frame. It produces one 8-bit value per colour component, registered one clock after the pixel is presented.

Each component is the sum, modulo 256, of up to three sources:

- a white frame outline around the active area;
- a horizontal ramp/ripple that advances with the pixels of a line;
- a vertical ramp/ripple that advances with the lines of a frame.

A ramp/ripple source adds an increment after a first interval. It then optionally subtracts a decrement after a second interval, and the two phases alternate. Arithmetic wraps instead of clipping, which gives sawtooth and ripple patterns. Each ramp source has its own enable bit per component. One control bit complements all outputs.

The block is used on a bring-up or test path ahead of a panel. It is driven by an external timing source, and its register inputs are set by the surrounding control logic.

Top module: `ramp_ripple_pattern`

## Requirements
- R1: While `rst_n` is low, `red`, `grn` and `blu` are 0.
- R2: The outputs present, one clock edge later, the value computed from the position, strobes and controls sampled at that edge. Before that edge they keep their previous value.
- R3: With second interval 0, the horizontal ramp value at a pixel is `inc * floor(p / s1)` modulo 256. Here `p` counts valid pixels since the last line or frame strobe, and the strobe pixel is p = 0. A first interval of 0 acts as 1. The vertical ramp follows the same rule with its own registers.
- R4: With second interval nonzero, let P = s1 + s2, k = floor(p / P) and r = p mod P. The ramp value is `k*(inc - dec)`, plus `inc` when r >= s1, all modulo 256.
- R5: Ramp values wrap modulo 256 on both overflow and underflow; they never saturate.
- R6: The vertical ramp value is computed by the R3/R4 rules with p = number of line strobes since the frame strobe (first line p = 0). It is constant over all pixels of a line.
- R7: Enable vectors `h_en` and `v_en` use bit 0 for red, bit 1 for green and bit 2 for blue. A clear bit makes that ramp contribute 0 to that component.
- R8: With `border_en` set, every component receives 255 on column 0, on column `act_w-1`, on line 0 and on line `act_h-1`. Elsewhere the border contributes 0.
- R9: Each component equals border + enabled horizontal + enabled vertical contribution, modulo 256.
- R10: With `invert` set, every bit of every component is complemented after the summation.
- R11: A cycle with `pix_valid` low does not advance either ramp, and its strobes are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pix_valid | input | 1 | Current cycle carries a pixel |
| frame_start | input | 1 | First pixel of a frame (also starts a line) |
| line_start | input | 1 | First pixel of a line |
| col | input | PW | Column position of the pixel |
| line | input | PW | Line position of the pixel |
| act_w | input | PW | Active width in pixels |
| act_h | input | PW | Active height in lines |
| border_en | input | 1 | White outline enable, all components |
| invert | input | 1 | Complement all output bits |
| h_en | input | 3 | Horizontal ramp enable per component (b0 red, b1 green, b2 blue) |
| h_s1 | input | SW | Horizontal first interval |
| h_s2 | input | SW | Horizontal second interval, 0 disables the decrement phase |
| h_inc | input | CW | Horizontal increment |
| h_dec | input | CW | Horizontal decrement |
| v_en | input | 3 | Vertical ramp enable per component (b0 red, b1 green, b2 blue) |
| v_s1 | input | SW | Vertical first interval |
| v_s2 | input | SW | Vertical second interval |
| v_inc | input | CW | Vertical increment |
| v_dec | input | CW | Vertical decrement |
| red | output | CW | Red component |
| grn | output | CW | Green component |
| blu | output | CW | Blue component |

## Verification
The bench runs a pure increment ramp past 255. A design that saturated would flatten at the top instead of restarting low. It also runs a ripple whose decrement exceeds its increment, so a design that clipped at zero or swapped the two intervals would show a wrong sawtooth.

Idle cycles are inserted between pixels to expose a ramp that advances on every clock rather than on valid pixels. A second frame is run after the first to expose a vertical ramp that misses the frame restart.

Full-sum and inverted runs mix border, horizontal and vertical sources on different components. These catch a wrong enable bit, wrong carry handling or an inversion applied before the sum.

// File: rtl/ramp_ripple_pattern.sv
module ramp_ripple_pattern #(
  parameter int CW = 8,
  parameter int PW = 12,
  parameter int SW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          pix_valid,
  input  logic          frame_start,
  input  logic          line_start,
  input  logic [PW-1:0] col,
  input  logic [PW-1:0] line,
  input  logic [PW-1:0] act_w,
  input  logic [PW-1:0] act_h,
  input  logic          border_en,
  input  logic          invert,
  input  logic [2:0]    h_en,
  input  logic [SW-1:0] h_s1,
  input  logic [SW-1:0] h_s2,
  input  logic [CW-1:0] h_inc,
  input  logic [CW-1:0] h_dec,
  input  logic [2:0]    v_en,
  input  logic [SW-1:0] v_s1,
  input  logic [SW-1:0] v_s2,
  input  logic [CW-1:0] v_inc,
  input  logic [CW-1:0] v_dec,
  output logic [CW-1:0] red,
  output logic [CW-1:0] grn,
  output logic [CW-1:0] blu
);

  typedef struct packed {
    logic [CW-1:0] val;
    logic [SW-1:0] cnt;
    logic          dn;
  } ramp_t;

  function automatic ramp_t advance(ramp_t s, logic [SW-1:0] s1, logic [SW-1:0] s2,
                                    logic [CW-1:0] inc, logic [CW-1:0] dec);
    ramp_t         n;
    logic [SW:0]   nxt;
    logic [SW-1:0] lim;
    n   = s;
    nxt = {1'b0, s.cnt} + 1'b1;
    lim = s.dn ? s2 : s1;
    if (nxt >= {1'b0, lim}) begin
      n.cnt = '0;
      if (s.dn) begin
        n.val = s.val - dec;
        n.dn  = 1'b0;
      end else begin
        n.val = s.val + inc;
        n.dn  = (s2 != '0);
      end
    end else begin
      n.cnt = nxt[SW-1:0];
    end
    return n;
  endfunction

  ramp_t         h_q, v_q, h_cur, v_cur;
  logic [CW-1:0] v_hold, v_now, bord;
  logic          f_go, l_go, edge_hit;
  logic [CW-1:0] pix_q [3];

  assign f_go  = pix_valid & frame_start;
  assign l_go  = pix_valid & (line_start | frame_start);
  assign h_cur = l_go ? '0 : h_q;
  assign v_cur = f_go ? '0 : v_q;
  assign v_now = l_go ? v_cur.val : v_hold;

  assign edge_hit = (col == '0) || (col == PW'(act_w - 1'b1)) ||
                    (line == '0) || (line == PW'(act_h - 1'b1));
  assign bord = (border_en && edge_hit) ? {CW{1'b1}} : '0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      h_q    <= '0;
      v_q    <= '0;
      v_hold <= '0;
    end else if (pix_valid) begin
      h_q <= advance(h_cur, h_s1, h_s2, h_inc, h_dec);
      if (l_go) begin
        v_hold <= v_cur.val;
        v_q    <= advance(v_cur, v_s1, v_s2, v_inc, v_dec);
      end
    end
  end

  for (genvar k = 0; k < 3; k++) begin : g_chan
    logic [CW-1:0] sum;
    assign sum = bord + (h_en[k] ? h_cur.val : '0) + (v_en[k] ? v_now : '0);
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) pix_q[k] <= '0;
      else        pix_q[k] <= invert ? ~sum : sum;
    end
  end

  assign red = pix_q[0];
  assign grn = pix_q[1];
  assign blu = pix_q[2];

endmodule

// File: rtl/ramp_ripple_pattern_chk.sv
module ramp_ripple_pattern_chk #(
  parameter int CW = 8,
  parameter int PW = 12
) (
  input logic          clk,
  input logic          rst_n,
  input logic          border_en,
  input logic          invert,
  input logic [2:0]    h_en,
  input logic [2:0]    v_en,
  input logic [PW-1:0] col,
  input logic [CW-1:0] red,
  input logic [CW-1:0] grn,
  input logic [CW-1:0] blu
);

  logic rst_seen;
  always_ff @(posedge clk) rst_seen <= !rst_n;

  // R1
  always @(posedge clk)
    if (rst_seen === 1'b1 && !rst_n)
      reset_zero_chk: assert (red == '0 && grn == '0 && blu == '0);

  // R7
  all_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (h_en == 3'b000 && v_en == 3'b000 && !border_en && !invert)
      |=> (red == '0 && grn == '0 && blu == '0));

  // R10
  inv_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (h_en == 3'b000 && v_en == 3'b000 && !border_en && invert)
      |=> (red == '1 && grn == '1 && blu == '1));

  // R8
  border_left_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (border_en && h_en == 3'b000 && v_en == 3'b000 && !invert && col == '0)
      |=> (red == '1 && grn == '1 && blu == '1));

  // R9
  chan_match_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (h_en == 3'b111 && v_en == 3'b111) |=> (red == grn && grn == blu));

endmodule

bind ramp_ripple_pattern ramp_ripple_pattern_chk #(.CW(CW), .PW(PW)) u_chk (
  .clk(clk), .rst_n(rst_n), .border_en(border_en), .invert(invert),
  .h_en(h_en), .v_en(v_en), .col(col), .red(red), .grn(grn), .blu(blu)
);

// File: tb/sim_ramp_ripple_pattern.sv
module sim_ramp_ripple_pattern;
  localparam int CLK_PERIOD = 10;

  logic clk = 0, rst_n = 0;
  logic pix_valid = 0, frame_start = 0, line_start = 0;
  logic [11:0] col = 0, line = 0, act_w = 12'd8, act_h = 12'd5;
  logic border_en = 0, invert = 0;
  logic [2:0] h_en = 0, v_en = 0;
  logic [7:0] h_s1 = 0, h_s2 = 0, h_inc = 0, h_dec = 0;
  logic [7:0] v_s1 = 0, v_s2 = 0, v_inc = 0, v_dec = 0;
  logic [7:0] red, grn, blu;
  int checks = 0, errors = 0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  ramp_ripple_pattern u0 (
    .clk(clk), .rst_n(rst_n), .pix_valid(pix_valid), .frame_start(frame_start),
    .line_start(line_start), .col(col), .line(line), .act_w(act_w), .act_h(act_h),
    .border_en(border_en), .invert(invert),
    .h_en(h_en), .h_s1(h_s1), .h_s2(h_s2), .h_inc(h_inc), .h_dec(h_dec),
    .v_en(v_en), .v_s1(v_s1), .v_s2(v_s2), .v_inc(v_inc), .v_dec(v_dec),
    .red(red), .grn(grn), .blu(blu));

  function automatic logic [7:0] ramp_model(int p, int s1, int s2, int inc, int dec);
    int s, v;
    s = (s1 == 0) ? 1 : s1;
    if (s2 == 0) v = inc * (p / s);
    else v = (p / (s + s2)) * (inc - dec) + (((p % (s + s2)) >= s) ? inc : 0);
    return 8'(v);
  endfunction

  task automatic check8(string tag, string what, logic [7:0] act, logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
    end
  endtask

  task automatic run_frame(string tag, int nlines, int ncols, bit gap);
    logic [7:0] hv, vv, bv, e;
    for (int ln = 0; ln < nlines; ln++) begin
      for (int c = 0; c < ncols; c++) begin
        @(negedge clk);
        pix_valid = 1; col = 12'(c); line = 12'(ln);
        line_start = (c == 0); frame_start = (c == 0 && ln == 0);
        @(posedge clk); #1;
        hv = ramp_model(c, h_s1, h_s2, h_inc, h_dec);
        vv = ramp_model(ln, v_s1, v_s2, v_inc, v_dec);
        bv = (border_en && (c == 0 || c == act_w - 1 || ln == 0 || ln == act_h - 1)) ? 8'hFF : 8'h00;
        for (int k = 0; k < 3; k++) begin
          e = bv + (h_en[k] ? hv : 8'h00) + (v_en[k] ? vv : 8'h00);
          if (invert) e = ~e;
          check8(tag, (k == 0) ? "red" : (k == 1) ? "grn" : "blu",
                 (k == 0) ? red : (k == 1) ? grn : blu, e);
        end
        if (gap) begin
          @(negedge clk);
          pix_valid = 0; line_start = 1; frame_start = 1;
          @(posedge clk);
        end
      end
    end
    @(negedge clk);
    pix_valid = 0; line_start = 0; frame_start = 0;
  endtask

  task automatic cfg_clear();
    border_en = 0; invert = 0; h_en = 0; v_en = 0;
    h_s1 = 0; h_s2 = 0; h_inc = 0; h_dec = 0;
    v_s1 = 0; v_s2 = 0; v_inc = 0; v_dec = 0;
  endtask

  task automatic t_reset();
    repeat (3) @(posedge clk);
    #1;
    check8("R1", "red", red, 0);
    check8("R1", "grn", grn, 0);
    check8("R1", "blu", blu, 0);
    @(negedge clk); rst_n = 1;
  endtask

  task automatic t_h_plain();
    cfg_clear(); h_en = 3'b001; h_s1 = 3; h_inc = 40;
    run_frame("R3/R5/R7", 2, 24, 0);
    cfg_clear(); h_en = 3'b010; h_s1 = 0; h_inc = 7;
    run_frame("R3", 1, 6, 0);
  endtask

  task automatic t_h_ripple();
    cfg_clear(); h_en = 3'b010; h_s1 = 4; h_s2 = 2; h_inc = 50; h_dec = 20;
    run_frame("R4", 1, 30, 0);
  endtask

  task automatic t_underflow();
    cfg_clear(); h_en = 3'b100; h_s1 = 2; h_s2 = 1; h_inc = 10; h_dec = 30;
    run_frame("R5", 1, 20, 0);
  endtask

  task automatic t_gap();
    cfg_clear(); h_en = 3'b011; h_s1 = 3; h_s2 = 2; h_inc = 60; h_dec = 5;
    v_en = 3'b100; v_s1 = 1; v_inc = 9;
    run_frame("R11", 3, 12, 1);
  endtask

  task automatic t_vert();
    cfg_clear(); v_en = 3'b100; v_s1 = 2; v_inc = 30;
    run_frame("R6", 20, 3, 0);
    v_en = 3'b011; v_s1 = 3; v_s2 = 1; v_inc = 40; v_dec = 70;
    run_frame("R6", 12, 3, 0);
    run_frame("R6", 6, 3, 0);
  endtask

  task automatic t_border();
    cfg_clear(); border_en = 1;
    run_frame("R8", 5, 8, 0);
  endtask

  task automatic t_sum();
    cfg_clear(); border_en = 1;
    h_en = 3'b011; h_s1 = 2; h_s2 = 3; h_inc = 90; h_dec = 25;
    v_en = 3'b110; v_s1 = 1; v_inc = 77;
    run_frame("R9", 5, 8, 0);
  endtask

  task automatic t_invert();
    cfg_clear(); invert = 1; border_en = 1;
    h_en = 3'b101; h_s1 = 1; h_inc = 33;
    v_en = 3'b010; v_s1 = 2; v_inc = 100;
    run_frame("R10", 5, 8, 0);
  endtask

  task automatic t_latency();
    cfg_clear(); border_en = 1;
    @(negedge clk);
    pix_valid = 1; col = 3; line = 2; line_start = 0; frame_start = 0;
    @(posedge clk); #1;
    check8("R2", "interior red", red, 0);
    @(negedge clk);
    col = 0;
    #1;
    check8("R2", "red before edge", red, 0);
    @(posedge clk); #1;
    check8("R2", "red after edge", red, 8'hFF);
    @(negedge clk);
    pix_valid = 0; col = 3;
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    t_reset();
    t_latency();
    t_h_plain();
    t_h_ripple();
    t_underflow();
    t_gap();
    t_vert();
    t_border();
    t_sum();
    t_invert();
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule